// File: doc/BRIEF.md
# System-Control Register File

This block holds the thirty-two 64-bit control registers of a processor's system-control coprocessor. Software writes one register per cycle through a single write port and reads any register through a combinational read port. Each register has its own write mask. A write may replace the whole register, replace only some fields and keep the others, clear bits the hardware does not implement, or be ignored entirely. Counters, interrupt logic and address-translation logic sit outside this block. Here the timer, compare and cause registers are plain storage.

Every write also loads the full write value into a shared holding register. Reads of the slots that have no register behind them return that holding value. This reproduces the way the bus keeps the last value driven on it. When a write to the status register changes the floating-point register-mode bit, the block raises a one-cycle pulse so that the register-file remapping logic can react.

The write port carries no back-pressure. It is always ready, and a write is taken on every rising clock edge where `wr_valid` is high. Reset is synchronous and active high.

Top module: `sysctl_regfile`

## Requirements
- R1: Every accepted write stores all 64 bits of `wr_data` in a shared holding register. Reads of slots 7, 21, 22, 23, 24, 25 and 31 return that holding value, and the read reflects a write from the next cycle on.
- R2: Synchronous reset clears all registers and the holding register to zero, and drives `fr_toggle` low.
- R3: A write to slot 4 loads bits 63..23 from the write data and keeps bits 22..4. Bits 3..0 become zero.
- R4: A write to slot 6 loads bits 5..0 from the write data. Bits 63..6 become zero.
- R5: Writes to slots 8, 15 and 27 leave those registers unchanged.
- R6: A write to slot 12 stores the write data with bit 19 forced to zero.
- R7: `fr_toggle` is high for exactly the one cycle after a write to slot 12 whose bit 26 differs from the stored bit 26. It is low in every other cycle.
- R8: A write to slot 16 takes the bits of mask 0x3F00800F from the write data and keeps the bits of mask 0xC0FF7FF0. All other bits become zero.
- R9: A write to slot 17 loads bits 31..0 and keeps bits 63..32.
- R10: A write to slot 20 loads bits 63..33 and keeps bits 32..0.
- R11: A write to slot 26 loads bits 7..0. Bits 63..8 become zero.
- R12: Every other slot is a plain 64-bit read/write register. A write to one slot leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write request. Always accepted. |
| wr_idx | input | 5 | Slot being written |
| wr_data | input | 64 | Write value |
| rd_idx | input | 5 | Slot being read |
| rd_data | output | 64 | Read value (combinational) |
| fr_toggle | output | 1 | One-cycle pulse when the status register's mode bit changes |

## Verification
The bench writes all ones to each masked slot, so a wrong or shifted mask shows up as a stray or missing bit in the read value. Unused slots are read after writes to other slots. A design that returned stored contents, or that latched only on writes to unused slots, would then read back zero or a stale value. Status writes are made with the mode bit set, with it left unchanged, and with it cleared. A pulse that fires on every status write, or that misses a clearing edge, fails the toggle check. A reset in the middle of the run must clear both real registers and the holding register.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int XLEN   = 64;
  localparam int NREG   = 32;
  localparam int IDX_W  = $clog2(NREG);
  localparam int STATUS_SLOT = 12;
  localparam int MODE_BIT    = 26;

  function automatic logic is_alias(input int unsigned slot);
    case (slot)
      7, 21, 22, 23, 24, 25, 31: is_alias = 1'b1;
      default:                   is_alias = 1'b0;
    endcase
  endfunction

  // bits loaded from write data
  function automatic logic [XLEN-1:0] take_mask(input int unsigned slot);
    case (slot)
      4:                         take_mask = 64'hFFFF_FFFF_FF80_0000;
      6:                         take_mask = 64'h0000_0000_0000_003F;
      8, 15, 27:                 take_mask = '0;
      7, 21, 22, 23, 24, 25, 31: take_mask = '0;
      12:                        take_mask = 64'hFFFF_FFFF_FFF7_FFFF;
      16:                        take_mask = 64'h0000_0000_3F00_800F;
      17:                        take_mask = 64'h0000_0000_FFFF_FFFF;
      20:                        take_mask = 64'hFFFF_FFFE_0000_0000;
      26:                        take_mask = 64'h0000_0000_0000_00FF;
      default:                   take_mask = '1;
    endcase
  endfunction

  // bits retained from previous contents
  function automatic logic [XLEN-1:0] keep_mask(input int unsigned slot);
    case (slot)
      4:                         keep_mask = 64'h0000_0000_007F_FFF0;
      8, 15, 27:                 keep_mask = '1;
      7, 21, 22, 23, 24, 25, 31: keep_mask = '1;
      16:                        keep_mask = 64'h0000_0000_C0FF_7FF0;
      17:                        keep_mask = 64'hFFFF_FFFF_0000_0000;
      20:                        keep_mask = 64'h0000_0001_FFFF_FFFF;
      default:                   keep_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_slot.sv
module sysctl_slot
  import sysctl_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] q
);
  localparam logic [XLEN-1:0] TAKE = take_mask(SLOT);
  localparam logic [XLEN-1:0] KEEP = keep_mask(SLOT);

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= (wr_data & TAKE) | (q & KEEP);
  end
endmodule

// File: rtl/sysctl_hold.sv
module sysctl_hold
  import sysctl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  output logic [XLEN-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (wr_en) q <= wr_data;
  end
endmodule

// File: rtl/sysctl_mode_edge.sv
module sysctl_mode_edge (
  input  logic clk,
  input  logic rst,
  input  logic status_we,
  input  logic old_bit,
  input  logic new_bit,
  output logic pulse
);
  always_ff @(posedge clk) begin
    if (rst) pulse <= 1'b0;
    else     pulse <= status_we && (old_bit != new_bit);
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data,
  output logic             fr_toggle
);
  logic [XLEN-1:0] regs_q [NREG];
  logic [XLEN-1:0] hold_q;
  logic [NREG-1:0] alias_map;

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    sysctl_slot #(.SLOT(g)) u_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (wr_valid && (wr_idx == IDX_W'(g))),
      .wr_data (wr_data),
      .q       (regs_q[g])
    );
    assign alias_map[g] = is_alias(g);
  end

  sysctl_hold u_hold (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_valid),
    .wr_data (wr_data),
    .q       (hold_q)
  );

  sysctl_mode_edge u_edge (
    .clk       (clk),
    .rst       (rst),
    .status_we (wr_valid && (wr_idx == IDX_W'(STATUS_SLOT))),
    .old_bit   (regs_q[STATUS_SLOT][MODE_BIT]),
    .new_bit   (wr_data[MODE_BIT]),
    .pulse     (fr_toggle)
  );

  always_comb begin
    if (alias_map[rd_idx]) rd_data = hold_q;
    else                   rd_data = regs_q[rd_idx];
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk (
  input logic        clk,
  input logic        rst,
  input logic        wr_valid,
  input logic [4:0]  wr_idx,
  input logic [63:0] wr_data,
  input logic [4:0]  rd_idx,
  input logic [63:0] rd_data,
  input logic        fr_toggle,
  input logic [63:0] regs_q [32]
);
  p_latch_readback_r1: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> (rd_idx != 5'd7 || rd_data == $past(wr_data)));

  p_context_low_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_idx == 5'd4) |=> (regs_q[4][3:0] == 4'h0));

  p_wired_high_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_idx == 5'd6) |=> (regs_q[6][63:6] == '0));

  p_ro_stable_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_idx == 5'd8) |=> $stable(regs_q[8]));

  p_status_bit19_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_idx == 5'd12) |=> !regs_q[12][19]);

  p_fr_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_idx == 5'd12 && wr_data[26] != regs_q[12][26]) |=> fr_toggle);

  p_fr_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && wr_idx == 5'd12) |=> !fr_toggle);

  p_lladdr_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_idx == 5'd17) |=> $stable(regs_q[17][63:32]));
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_valid  (wr_valid),
  .wr_idx    (wr_idx),
  .wr_data   (wr_data),
  .rd_idx    (rd_idx),
  .rd_data   (rd_data),
  .fr_toggle (fr_toggle),
  .regs_q    (regs_q)
);

// File: tb/sim_sysctl_regfile.sv
module sim_sysctl_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  rd_idx = '0;
  logic [63:0] rd_data;
  logic        fr_toggle;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit status_mode = 1'b0;

  always #10 clk = ~clk;

  sysctl_regfile u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .fr_toggle(fr_toggle)
  );

  // {slot, write value, expected read value}
  localparam logic [132:0] VEC [15] = '{
    {5'd1,  64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF},  // R12
    {5'd4,  64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FF80_0000},  // R3
    {5'd6,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_003F},  // R4
    {5'd8,  64'hFFFF_FFFF_FFFF_FFFF, 64'h0},                    // R5
    {5'd15, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},                    // R5
    {5'd27, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0},                    // R5
    {5'd12, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFF7_FFFF},  // R6
    {5'd16, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_3F00_800F},  // R8
    {5'd17, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF},  // R9
    {5'd20, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFE_0000_0000},  // R10
    {5'd26, 64'h0000_0000_0000_1234, 64'h0000_0000_0000_0034},  // R11
    {5'd7,  64'hA5A5_A5A5_A5A5_A5A5, 64'hA5A5_A5A5_A5A5_A5A5},  // R1
    {5'd31, 64'h5A5A_5A5A_5A5A_5A5A, 64'h5A5A_5A5A_5A5A_5A5A},  // R1
    {5'd30, 64'hDEAD_BEEF_0000_1111, 64'hDEAD_BEEF_0000_1111},  // R12
    {5'd23, 64'h0000_0000_0000_0BAD, 64'h0000_0000_0000_0BAD}   // R1
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // write on the next edge; afterwards fr_toggle shows that write's pulse
  task automatic do_write(input logic [4:0] idx, input logic [63:0] data);
    @(negedge clk);
    wr_valid = 1'b1; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic read_chk(input string req, input logic [4:0] idx, input logic [63:0] exp);
    rd_idx = idx;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic write_fr(input string req, input logic [63:0] data, input bit exp_pulse);
    do_write(5'd12, data);
    check(req, {63'd0, fr_toggle}, {63'd0, exp_pulse});
    @(negedge clk);
    check("R7 pulse width", {63'd0, fr_toggle}, 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    check("R2 fr_toggle", {63'd0, fr_toggle}, 64'd0);
    read_chk("R2 slot 1", 5'd1, 64'h0);
    read_chk("R2 slot 7", 5'd7, 64'h0);
    read_chk("R2 slot 12", 5'd12, 64'h0);

    for (int i = 0; i < 15; i++) begin
      logic [4:0]  vi;
      logic [63:0] vd, ve;
      bit          exp_p;
      {vi, vd, ve} = VEC[i];
      exp_p = (vi == 5'd12) && (vd[26] != status_mode);
      do_write(vi, vd);
      check("R7 table pulse", {63'd0, fr_toggle}, {63'd0, exp_p});
      if (vi == 5'd12) status_mode = vd[26] & 1'b1;
      read_chk("R1-table readback", vi, ve);
    end

    // R1: all unused slots share the holding value
    do_write(5'd2, 64'h1111_2222_3333_4444);
    read_chk("R1 slot 21", 5'd21, 64'h1111_2222_3333_4444);
    read_chk("R1 slot 25", 5'd25, 64'h1111_2222_3333_4444);
    read_chk("R12 slot 2", 5'd2, 64'h1111_2222_3333_4444);
    // R12: earlier registers untouched by other writes
    read_chk("R12 slot 1 kept", 5'd1, 64'h0123_4567_89AB_CDEF);
    read_chk("R12 slot 30 kept", 5'd30, 64'hDEAD_BEEF_0000_1111);
    // R5: read-only still zero after unrelated writes
    do_write(5'd8, 64'h0000_0000_0000_0001);
    read_chk("R5 slot 8", 5'd8, 64'h0);
    read_chk("R1 after ro write", 5'd31, 64'h1);

    // R7: status mode bit is currently 1
    write_fr("R7 same bit no pulse", 64'h0000_0000_0400_0000, 1'b0);
    write_fr("R7 clear bit pulse",   64'h0000_0000_0000_0000, 1'b1);
    write_fr("R7 set bit pulse",     64'h0000_0000_0408_0000, 1'b1);
    read_chk("R6 bit19 cleared", 5'd12, 64'h0000_0000_0400_0000);
    do_write(5'd13, 64'h0000_0000_0400_0000);
    check("R7 other slot no pulse", {63'd0, fr_toggle}, 64'd0);

    // R3: context partial overwrite
    do_write(5'd4, 64'h0000_0000_00FF_FFFF);
    read_chk("R3 context", 5'd4, 64'h0000_0000_0080_0000);

    // R2: reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    read_chk("R2 slot 1 after reset", 5'd1, 64'h0);
    read_chk("R2 slot 31 after reset", 5'd31, 64'h0);
    read_chk("R2 slot 12 after reset", 5'd12, 64'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule